// File: doc/BRIEF.md
# Instruction fetch stage

This block is the front end of a small processor that keeps instructions and data in separate memories. It holds a program counter and uses it to read a 16-bit word from its own instruction store. Each instruction fills exactly one word. The next address is chosen in one of two ways. During normal flow it is the current address plus one, wrapping at the top of the address space. When the branch control is high it is an address supplied from outside. The fetched word and the address it came from are caught in a barrier register, together with a valid flag, and the decode stage reads them from there.

The whole stage moves only on a clock edge where the advance input is high. The output side is a stream toward decode: `dec_valid_o` marks a held instruction, and `adv_i` acts as the downstream ready. While `adv_i` is low, the barrier outputs and the program counter hold their values, and the branch inputs have no effect. A transfer to decode happens on every edge where `adv_i` is high. The instruction store is filled through a load port, which is honoured only while `rst_i` is high. During execution the store is read-only.

Top module: `fetch_stage`

## Requirements
- R1: On a clock edge with `rst_i` high, `dec_valid_o` becomes 0, `dec_instr_o` becomes 0 and `dec_pc_o` becomes 0, and the program counter returns to address 0. The next advance therefore fetches address 0.
- R2: On an edge with `adv_i` high and `br_take_i` low, the barrier captures the current address and the word stored there. The program counter then moves to that address plus one.
- R3: On an edge with `adv_i` and `br_take_i` both high, the barrier still captures the current address and its word. The following fetch uses `br_addr_i`.
- R4: On an edge with `adv_i` low, `dec_valid_o`, `dec_instr_o` and `dec_pc_o` keep their values and the program counter does not move, whatever the branch inputs are.
- R5: Sequential flow from the last address, 4095 with the default 12-bit address, continues at address 0.
- R6: A write on the load port (`ld_we_i`, `ld_addr_i`, `ld_data_i`) changes the store only when `rst_i` is high on that edge. A write attempted while `rst_i` is low is ignored.
- R7: `rst_i` takes priority over `adv_i` and `br_take_i` on the same edge.
- R8: `dec_valid_o` goes to 1 on the first advance after reset and stays at 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high; opens the load port |
| adv_i | input | 1 | Advance trigger / decode ready |
| br_take_i | input | 1 | Select the branch address as the next fetch address |
| br_addr_i | input | 12 | Branch target word address |
| ld_we_i | input | 1 | Program-load write enable (honoured in reset only) |
| ld_addr_i | input | 12 | Program-load word address |
| ld_data_i | input | 16 | Program-load instruction word |
| dec_valid_o | output | 1 | Barrier holds a fetched instruction |
| dec_instr_o | output | 16 | Instruction held for decode |
| dec_pc_o | output | 12 | Address of the held instruction |

## Verification
An advance shows up on the barrier outputs after exactly one rising edge. A branch or an increment changes only the address of the fetch after that, so its effect is two advances away. The bench sets inputs on the falling edge and reads the outputs a few nanoseconds after the next rising edge. It expects each vector's result in that window and expects a branch target one row later in the vector table. Effects that cannot be seen directly, such as an ignored load or a stalled program counter, are checked at the next advance that fetches the address involved.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  // source chosen for the next fetch address
  typedef enum logic {
    SEL_SEQ    = 1'b0,
    SEL_BRANCH = 1'b1
  } pc_sel_e;

  localparam int unsigned DEF_ADDR_W  = 12;
  localparam int unsigned DEF_INSTR_W = 16;
endpackage

// File: rtl/fetch_pc.sv
module fetch_pc
  import fetch_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              adv_i,
  input  logic              br_take_i,
  input  logic [ADDR_W-1:0] br_addr_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  pc_sel_e           sel;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_inc;
  logic [ADDR_W-1:0] pc_nxt;

  // incrementer wraps naturally at 2**ADDR_W
  assign pc_inc = pc_q + ONE;
  assign sel    = br_take_i ? SEL_BRANCH : SEL_SEQ;

  always_comb begin
    unique case (sel)
      SEL_BRANCH: pc_nxt = br_addr_i;
      default:    pc_nxt = pc_inc;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)      pc_q <= '0;
    else if (adv_i) pc_q <= pc_nxt;
  end

  assign pc_o = pc_q;

  a_r2_seq_step: assert property (@(posedge clk_i) disable iff (rst_i)
    (adv_i && !br_take_i) |=> (pc_q == $past(pc_q) + ONE));
  a_r3_branch_load: assert property (@(posedge clk_i) disable iff (rst_i)
    (adv_i && br_take_i) |=> (pc_q == $past(br_addr_i)));
  a_r4_pc_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !adv_i |=> $stable(pc_q));
endmodule

// File: rtl/fetch_imem.sv
module fetch_imem #(
  parameter int unsigned ADDR_W  = fetch_pkg::DEF_ADDR_W,
  parameter int unsigned INSTR_W = fetch_pkg::DEF_INSTR_W
) (
  input  logic               clk_i,
  input  logic               load_en_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  waddr_i,
  input  logic [INSTR_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]  raddr_i,
  output logic [INSTR_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [INSTR_W-1:0] mem [DEPTH];
  logic               wr_ok;

  // writes only pass while the stage is held in reset
  assign wr_ok = we_i && load_en_i;

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/fetch_barrier.sv
module fetch_barrier #(
  parameter int unsigned ADDR_W  = fetch_pkg::DEF_ADDR_W,
  parameter int unsigned INSTR_W = fetch_pkg::DEF_INSTR_W
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               adv_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               valid_o,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [INSTR_W-1:0] instr_o
);
  logic               vld_q;
  logic [ADDR_W-1:0]  pc_q;
  logic [INSTR_W-1:0] ins_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      vld_q <= 1'b0;
      pc_q  <= '0;
      ins_q <= '0;
    end else if (adv_i) begin
      vld_q <= 1'b1;
      pc_q  <= pc_i;
      ins_q <= instr_i;
    end
  end

  assign valid_o = vld_q;
  assign pc_o    = pc_q;
  assign instr_o = ins_q;

  a_r4_out_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !adv_i |=> ($stable(ins_q) && $stable(pc_q) && $stable(vld_q)));
  a_r8_valid_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    vld_q |=> vld_q);
  a_r8_valid_first: assert property (@(posedge clk_i) disable iff (rst_i)
    adv_i |=> vld_q);
  a_r2_capture_pc: assert property (@(posedge clk_i) disable iff (rst_i)
    adv_i |=> (pc_q == $past(pc_i)));
endmodule

// File: rtl/fetch_stage.sv
module fetch_stage
  import fetch_pkg::*;
#(
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned INSTR_W = DEF_INSTR_W
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               adv_i,
  input  logic               br_take_i,
  input  logic [ADDR_W-1:0]  br_addr_i,
  input  logic               ld_we_i,
  input  logic [ADDR_W-1:0]  ld_addr_i,
  input  logic [INSTR_W-1:0] ld_data_i,
  output logic               dec_valid_o,
  output logic [INSTR_W-1:0] dec_instr_o,
  output logic [ADDR_W-1:0]  dec_pc_o
);
  logic [ADDR_W-1:0]  pc;
  logic [INSTR_W-1:0] rd_word;

  fetch_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .adv_i     (adv_i),
    .br_take_i (br_take_i),
    .br_addr_i (br_addr_i),
    .pc_o      (pc)
  );

  fetch_imem #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_imem (
    .clk_i     (clk_i),
    .load_en_i (rst_i),
    .we_i      (ld_we_i),
    .waddr_i   (ld_addr_i),
    .wdata_i   (ld_data_i),
    .raddr_i   (pc),
    .rdata_o   (rd_word)
  );

  fetch_barrier #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_bar (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .adv_i   (adv_i),
    .pc_i    (pc),
    .instr_i (rd_word),
    .valid_o (dec_valid_o),
    .pc_o    (dec_pc_o),
    .instr_o (dec_instr_o)
  );

  // R7: reset wins over advance and branch on the same edge
  a_r7_reset_wins: assert property (@(posedge clk_i)
    (rst_i && adv_i) |=> (!dec_valid_o && dec_pc_o == '0 && dec_instr_o == '0));
endmodule

// File: tb/sim_fetch_stage.sv
module sim_fetch_stage;
  localparam int AW = 12;
  localparam int IW = 16;
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst_i, adv_i, br_take_i, ld_we_i;
  logic [AW-1:0] br_addr_i, ld_addr_i;
  logic [IW-1:0] ld_data_i;
  logic          dec_valid_o;
  logic [IW-1:0] dec_instr_o;
  logic [AW-1:0] dec_pc_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  fetch_stage u0 (
    .clk_i(clk), .rst_i(rst_i), .adv_i(adv_i), .br_take_i(br_take_i),
    .br_addr_i(br_addr_i), .ld_we_i(ld_we_i), .ld_addr_i(ld_addr_i),
    .ld_data_i(ld_data_i), .dec_valid_o(dec_valid_o),
    .dec_instr_o(dec_instr_o), .dec_pc_o(dec_pc_o)
  );

  function automatic logic [IW-1:0] pat(int a);
    logic [IW-1:0] r;
    r = IW'(a * 37) ^ 16'hC3A5;
    return r;
  endfunction

  // {adv, br, br_addr[11:0], expected dec_pc[11:0]}
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 1'b0, 12'd0,    12'd0},    // R8 first advance, R2
    {1'b1, 1'b0, 12'd0,    12'd1},    // R2
    {1'b0, 1'b1, 12'd100,  12'd1},    // R4 stall, branch ignored
    {1'b1, 1'b1, 12'd100,  12'd2},    // R3 branch requested
    {1'b1, 1'b0, 12'd0,    12'd100},  // R3 target fetched
    {1'b1, 1'b1, 12'd4094, 12'd101},
    {1'b1, 1'b0, 12'd0,    12'd4094},
    {1'b1, 1'b0, 12'd0,    12'd4095}, // R5 last address
    {1'b1, 1'b0, 12'd0,    12'd0},    // R5 wrapped
    {1'b0, 1'b0, 12'd0,    12'd0},    // R4
    {1'b1, 1'b1, 12'd7,    12'd1},
    {1'b1, 1'b0, 12'd0,    12'd7}     // R3
  };

  task automatic check(string req, logic v, logic [AW-1:0] p, logic [IW-1:0] ins);
    n_chk++;
    if (dec_valid_o !== v || dec_pc_o !== p || dec_instr_o !== ins) begin
      n_bad++;
      $display("FAIL %s: got v=%0b pc=%0d ins=%h, want v=%0b pc=%0d ins=%h",
               req, dec_valid_o, dec_pc_o, dec_instr_o, v, p, ins);
    end
  endtask

  // drive on falling edge, sample 5 ns after the following rising edge
  task automatic cyc(logic r, logic a, logic b, logic [AW-1:0] ba);
    @(negedge clk);
    rst_i = r; adv_i = a; br_take_i = b; br_addr_i = ba;
    @(posedge clk);
    #5;
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, want completion");
      finish_up();
    end
  end

  initial begin
    rst_i = 1; adv_i = 0; br_take_i = 0; br_addr_i = '0;
    ld_we_i = 0; ld_addr_i = '0; ld_data_i = '0;
    // fill the store while held in reset
    for (int a = 0; a < (1 << AW); a++) begin
      @(negedge clk);
      ld_we_i = 1; ld_addr_i = AW'(a); ld_data_i = pat(a);
    end
    @(negedge clk);
    ld_we_i = 0;
    // R1 reset state, with advance and branch also high (R7)
    cyc(1, 1, 1, 12'd50);
    check("R1", 0, 0, 0);
    check("R7", 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      cyc(0, v[25], v[24], v[23:12]);
      check(i == 8 ? "R5" : (v[25] ? "R2" : "R4"), 1, v[11:0], pat(int'(v[11:0])));
    end

    // R6: a load attempted outside reset is ignored
    @(negedge clk);
    rst_i = 0; adv_i = 0; br_take_i = 0;
    ld_we_i = 1; ld_addr_i = 12'd5; ld_data_i = 16'hBEEF;
    @(posedge clk); #5;
    check("R6", 1, 12'd7, pat(7));
    @(negedge clk); ld_we_i = 0;
    cyc(0, 1, 1, 12'd5);
    check("R3", 1, 12'd8, pat(8));
    cyc(0, 1, 0, 12'd0);
    check("R6", 1, 12'd5, pat(5));

    // R7: reset mid-run beats advance and branch
    cyc(1, 1, 1, 12'd300);
    check("R7", 0, 0, 0);
    // R6: a load during reset is honoured
    @(negedge clk);
    ld_we_i = 1; ld_addr_i = 12'd6; ld_data_i = 16'h1234;
    @(posedge clk); #5;
    @(negedge clk); ld_we_i = 0;
    cyc(0, 0, 0, 12'd0);
    check("R8", 0, 0, 0);
    cyc(0, 1, 1, 12'd6);
    check("R1", 1, 12'd0, pat(0));
    cyc(0, 1, 0, 12'd0);
    check("R6", 1, 12'd6, 16'h1234);
    cyc(0, 0, 0, 12'd0);
    check("R8", 1, 12'd6, 16'h1234);

    done = 1;
    finish_up();
  end
endmodule